// File: doc/BRIEF.md
# Program/Erase Busy Status Generator

This block produces the byte a host sees when it reads a byte-wide flash device while an internal program or erase operation runs. A one-cycle start request, qualified by an operation code, launches a cycle-count timer. The timer's length comes from one of three terminal-count inputs, one for each operation. Until the timer expires, every host read returns a status byte instead of array contents. After expiry, reads pass the true array byte through unchanged.

Two polling schemes run side by side. The top status bit carries the complement of the top bit of the byte being written. For the two erase operations the block treats that byte as all ones, so the bit reads 0 while busy and 1 once the erase completes. The bit below it flips once per completed read strobe, and the first read after a start returns 0. A host can therefore wait for the top bit to match its data, or read twice and compare the toggle bit. Array storage and command decoding sit outside this block.

Top module: `pgm_busy_status`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o` is 0 and `dout_o` equals `array_i`.
- R2: A start accepted while idle raises `busy_o` at the next clock edge. `busy_o` then stays high for exactly TC+1 clock cycles. TC is the terminal count of the selected operation, sampled when the start is accepted. The operation codes are 0 = byte program (`tc_prog_i`), 1 = page erase (`tc_page_i`) and 2 = chip erase (`tc_chip_i`).
- R3: While busy, `dout_o[7]` equals the inverse of `wdata_i[7]` as captured at start for byte program. For both erase codes it is 0, because the target byte is taken as FFh.
- R4: While busy, `dout_o[6]` is 0 after start. It inverts once for each completed read strobe, meaning a high-to-low transition of `rd_i`. It keeps its value while the strobe is held high and while no read occurs.
- R5: While busy, `dout_o[5:0]` is zero.
- R6: While idle, `dout_o` follows `array_i` on all eight bits, so the toggle bit stops changing once the operation completes.
- R7: A start that arrives while busy is ignored. It neither restarts the timer nor replaces the captured target data.
- R8: A start with operation code 3 is ignored, and `busy_o` stays 0.
- R9: A change on any terminal-count input during a running operation does not alter that operation's duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start request (end of the launching write) |
| op_i | input | 2 | Operation code: 0 program, 1 page erase, 2 chip erase, 3 reserved |
| wdata_i | input | 8 | Byte being programmed, sampled with the start |
| array_i | input | 8 | True array byte at the read address |
| rd_i | input | 1 | Host read strobe, active high |
| tc_prog_i | input | CNT_W | Terminal count for byte program |
| tc_page_i | input | CNT_W | Terminal count for page erase |
| tc_chip_i | input | CNT_W | Terminal count for chip erase |
| dout_o | output | 8 | Byte returned to the host |
| busy_o | output | 1 | Operation in progress |

## Verification
The bench holds the read strobe high for several cycles. A toggle that advanced on every clock, or on a strobe level, would show a changed bit 6 there. Erase runs drive a `wdata_i` with bit 7 clear, so a design that used the bus byte instead of FFh would report bit 7 as 1. A second start during a program, and a terminal count rewritten mid-run, both expose a timer that reloads or reads its limit live: the measured busy length would drift from TC+1. The reserved code and the post-completion reads catch a block that goes busy on an invalid code or keeps toggling after it finishes.

// File: rtl/pgm_busy_status_pkg.sv
package pgm_busy_status_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_PAGE = 2'd1,
        OP_CHIP = 2'd2,
        OP_RSVD = 2'd3
    } op_e;

    localparam int DATA_W = 8;
    localparam int NUM_OPS = 3;

    typedef struct packed {
        logic tgt7;
        logic tgl;
        logic rd;
    } poll_t;

endpackage

// File: rtl/pbs_tc_mux.sv
module pbs_tc_mux
    import pgm_busy_status_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [1:0]       op_i,
    input  logic [CNT_W-1:0] tc_i [NUM_OPS],
    output logic [CNT_W-1:0] tc_o,
    output logic             valid_o
);

    logic [NUM_OPS-1:0] hit;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_hit
        assign hit[g] = (op_i == 2'(g));
    end

    always_comb begin
        tc_o = '0;
        for (int k = 0; k < NUM_OPS; k++) begin
            if (hit[k]) tc_o = tc_i[k];
        end
    end

    assign valid_o = |hit;

endmodule

// File: rtl/pbs_op_timer.sv
module pbs_op_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] tc_i,
    output logic             busy_o
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] tc;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = '0;
            tmr_d.tc   = tc_i;
        end else if (tmr_q.busy) begin
            if (tmr_q.cnt == tmr_q.tc) begin
                tmr_d.busy = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy_o = tmr_q.busy;

endmodule

// File: rtl/pbs_poll_bits.sv
module pbs_poll_bits
    import pgm_busy_status_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  logic        erase_i,
    input  logic        wbit7_i,
    input  logic        busy_i,
    input  logic        rd_i,
    output logic        tgt7_o,
    output logic        tgl_o
);

    poll_t poll_d, poll_q;

    always_comb begin
        poll_d    = poll_q;
        poll_d.rd = rd_i;
        if (load_i) begin
            poll_d.tgt7 = erase_i ? 1'b1 : wbit7_i;
            poll_d.tgl  = 1'b0;
        end else if (busy_i && poll_q.rd && !rd_i) begin
            poll_d.tgl = ~poll_q.tgl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) poll_q <= '0;
        else        poll_q <= poll_d;
    end

    assign tgt7_o = poll_q.tgt7;
    assign tgl_o  = poll_q.tgl;

endmodule

// File: rtl/pgm_busy_status.sv
module pgm_busy_status
    import pgm_busy_status_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       op_i,
    input  logic [7:0]       wdata_i,
    input  logic [7:0]       array_i,
    input  logic             rd_i,
    input  logic [CNT_W-1:0] tc_prog_i,
    input  logic [CNT_W-1:0] tc_page_i,
    input  logic [CNT_W-1:0] tc_chip_i,
    output logic [7:0]       dout_o,
    output logic             busy_o
);

    logic [CNT_W-1:0] tc_arr [NUM_OPS];
    logic [CNT_W-1:0] tc_sel;
    logic             op_ok;
    logic             accept;
    logic             busy;
    logic             tgt7;
    logic             tgl;

    assign tc_arr[OP_PROG] = tc_prog_i;
    assign tc_arr[OP_PAGE] = tc_page_i;
    assign tc_arr[OP_CHIP] = tc_chip_i;

    pbs_tc_mux #(.CNT_W(CNT_W)) tc_mux_i (
        .op_i    (op_i),
        .tc_i    (tc_arr),
        .tc_o    (tc_sel),
        .valid_o (op_ok)
    );

    // only an idle block with a legal code takes a start
    assign accept = start_i && !busy && op_ok;

    pbs_op_timer #(.CNT_W(CNT_W)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .tc_i   (tc_sel),
        .busy_o (busy)
    );

    pbs_poll_bits poll_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .erase_i (op_i != OP_PROG),
        .wbit7_i (wdata_i[7]),
        .busy_i  (busy),
        .rd_i    (rd_i),
        .tgt7_o  (tgt7),
        .tgl_o   (tgl)
    );

    always_comb begin
        if (busy) dout_o = {~tgt7, tgl, 6'b0};
        else      dout_o = array_i;
    end

    assign busy_o = busy;

endmodule

// File: rtl/pgm_busy_status_chk.sv
module pgm_busy_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [1:0] op_i,
    input logic [7:0] array_i,
    input logic [7:0] dout_o,
    input logic       busy_o
);

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i && op_i != 2'd3));

    // R3
    poll7_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(dout_o[7]));

    // R4
    tgl_first_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !dout_o[6]);

    // R5
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> dout_o[5:0] == 6'b0);

    // R6
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> dout_o == array_i);

    // R8
    rsvd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && op_i == 2'd3) |=> !busy_o);

endmodule

bind pgm_busy_status pgm_busy_status_chk chk_i (.*);

// File: tb/pgm_busy_status_tb_top.sv
module pgm_busy_status_tb_top;

    localparam int CW = 16;
    localparam int TC_P = 12;
    localparam int TC_G = 20;
    localparam int TC_C = 28;
    localparam int NV = 5;
    // {op[25:24], wdata[23:16], array[15:8], reads[7:0]}
    localparam logic [25:0] VEC [NV] = '{
        {2'd0, 8'h35, 8'h35, 8'd3},
        {2'd0, 8'hC8, 8'hC8, 8'd4},
        {2'd1, 8'h00, 8'hFF, 8'd5},
        {2'd2, 8'h5A, 8'hFF, 8'd6},
        {2'd0, 8'h80, 8'hA7, 8'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    op_i = 2'd0;
    logic [7:0]    wdata_i = 8'h00;
    logic [7:0]    array_i = 8'h00;
    logic          rd_i = 1'b0;
    logic [CW-1:0] tc_prog_i = CW'(TC_P);
    logic [CW-1:0] tc_page_i = CW'(TC_G);
    logic [CW-1:0] tc_chip_i = CW'(TC_C);
    logic [7:0]    dout_o;
    logic          busy_o;

    int errs = 0;
    int checks = 0;
    int busy_len = 0;

    always #4 clk = ~clk;

    pgm_busy_status #(.CNT_W(CW)) dut_i (.*);

    always @(negedge clk) if (busy_o) busy_len++;

    task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chkn(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_start(logic [1:0] op, logic [7:0] d);
        @(negedge clk);
        start_i = 1'b1; op_i = op; wdata_i = d; busy_len = 0;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic pulse_start(logic [1:0] op, logic [7:0] d);
        @(negedge clk);
        start_i = 1'b1; op_i = op; wdata_i = d;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic do_read(output logic [7:0] v);
        @(negedge clk);
        rd_i = 1'b1;
        @(negedge clk);
        v = dout_o;
        rd_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    function automatic int tc_of(logic [1:0] op);
        return (op == 2'd0) ? TC_P : (op == 2'd1) ? TC_G : TC_C;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] v2;
        array_i = 8'h6E;
        repeat (3) @(negedge clk);
        // R1 reset state
        chkn("R1 busy in reset", int'(busy_o), 0);
        chk8("R1 dout in reset", dout_o, 8'h6E);
        rst_n = 1'b1;
        @(negedge clk);
        chkn("R1 busy after reset", int'(busy_o), 0);
        chk8("R1 dout after reset", dout_o, 8'h6E);

        // table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            logic [1:0] op = VEC[i][25:24];
            logic [7:0] wd = VEC[i][23:16];
            logic [7:0] ar = VEC[i][15:8];
            int nrd = int'(VEC[i][7:0]);
            logic t7 = (op == 2'd0) ? wd[7] : 1'b1;
            array_i = ar;
            do_start(op, wd);
            chkn("R2 busy after start", int'(busy_o), 1);
            for (int r = 0; r < nrd; r++) begin
                do_read(v);
                chk8("R3 R4 R5 status byte", v, {~t7, r[0], 6'b0});
            end
            wait_idle();
            chkn("R2 busy length", busy_len, tc_of(op) + 1);
            do_read(v);
            do_read(v2);
            chk8("R6 first read after done", v, ar);
            chk8("R6 second read after done", v2, ar);
        end

        // R4: held strobe and idle periods do not advance the toggle
        array_i = 8'h11;
        do_start(2'd0, 8'h00);
        @(negedge clk); rd_i = 1'b1;
        repeat (4) @(negedge clk);
        chk8("R4 held strobe", dout_o, 8'h80);
        repeat (2) @(negedge clk);
        chk8("R4 held strobe later", dout_o, 8'h80);
        rd_i = 1'b0;
        @(negedge clk);
        chk8("R4 after strobe falls", dout_o, 8'hC0);
        repeat (3) @(negedge clk);
        chk8("R4 no reads", dout_o, 8'hC0);
        wait_idle();
        chk8("R6 idle byte", dout_o, 8'h11);
        array_i = 8'h99;
        @(negedge clk);
        chk8("R6 follows array", dout_o, 8'h99);

        // R7: second start while busy
        do_start(2'd0, 8'h12);
        repeat (2) @(negedge clk);
        pulse_start(2'd2, 8'hFF);
        @(negedge clk);
        chk8("R7 target kept", dout_o & 8'h80, 8'h80);
        wait_idle();
        chkn("R7 no restart", busy_len, TC_P + 1);

        // R8: reserved code
        array_i = 8'h3C;
        pulse_start(2'd3, 8'h00);
        chkn("R8 no busy", int'(busy_o), 0);
        chk8("R8 dout", dout_o, 8'h3C);

        // R9: terminal count changed mid-run
        do_start(2'd0, 8'h40);
        @(negedge clk);
        tc_prog_i = CW'(3);
        wait_idle();
        chkn("R9 length kept", busy_len, TC_P + 1);
        tc_prog_i = CW'(TC_P);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule